// File: doc/BRIEF.md
# Masked Interrupt Status Register Group

This block collects single-cycle event pulses from up to `NUM_SRC` hardware sources into sticky status bits and drives one level-sensitive interrupt line. The line is asserted while at least one status bit is set and its mask bit is clear. Software clears status bits by writing ones to them.

Software cannot write the mask register directly. A mask bit is cleared (the source is unmasked) by writing a one to the matching bit of the unmask alias word. A mask bit is set (the source is masked) by writing a one to the matching bit of the mask-set alias word. Neither alias word holds any state. Every source is masked when reset ends.

The register bus is a plain 32-bit interface with a byte address, a write strobe, write data and combinational read data. Only word-aligned accesses have any effect. The word map is: status at 0x0, mask at 0x4, unmask alias at 0x8, mask-set alias at 0xC.

Top module: `masked_irq_regs`

## Requirements
- R1: When reset is released, every status bit is 0, every mask bit is 1 (all `NUM_SRC` bits), and `irq_o` is 0.
- R2: `irq_o` equals the OR over all bits of (status AND NOT mask). It is registered, so it shows the effect of a write or an event one clock edge after the edge at which the status or mask changed.
- R3: A pulse on `evt_i[i]` sets status bit i at the next clock edge. The bit stays set after the pulse ends until software clears it.
- R4: A write to word 0x0 clears every status bit whose write-data bit is 1 and leaves unchanged every status bit whose write-data bit is 0.
- R5: If an event pulse and a clearing write target the same status bit on the same edge, the bit ends up set.
- R6: Word 0x4 reads back the mask in bits [NUM_SRC-1:0]. Bus writes to word 0x4 leave the mask unchanged.
- R7: A write to word 0x8 clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R8: A write to word 0xC sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R9: Words 0x8 and 0xC always read 0. Read-data bits at and above bit `NUM_SRC` always read 0.
- R10: An access with `addr_i[1:0]` not equal to 0 changes no state, and its read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| evt_i | input | NUM_SRC | Event pulses, one bit per source |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
Errors in the status or mask state show up in two places. The first is the read data of words 0x0 and 0x4, as soon as the edge that changed the state has passed. The second is `irq_o`, which is wrong exactly one edge later. A fault in an alias decode shows up as mask bits moving in the wrong direction, or not moving at all, after a single write. A fault in the set-versus-clear priority only appears when an event and a clearing write land on the same edge, so the bench drives that case on purpose. Misaligned writes that alter state are caught by reading the mask back after an all-ones write to a misaligned alias address.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int WORD_W      = 32;
  localparam int WORD_STATUS = 0;
  localparam int WORD_MASK   = 1;
  localparam int WORD_UNMASK = 2;
  localparam int WORD_MSKSET = 3;

  typedef struct packed {
    logic st;
    logic mk;
    logic um;
    logic ms;
  } word_sel_t;

  // Sticky status update: hardware set takes precedence over software clear.
  function automatic logic [WORD_W-1:0] status_next(input logic [WORD_W-1:0] q,
                                                    input logic [WORD_W-1:0] set,
                                                    input logic [WORD_W-1:0] clr);
    return (q & ~clr) | set;
  endfunction

  function automatic logic [WORD_W-1:0] mask_next(input logic [WORD_W-1:0] q,
                                                  input logic [WORD_W-1:0] unmask,
                                                  input logic [WORD_W-1:0] mskset);
    return (q & ~unmask) | mskset;
  endfunction

  function automatic logic pending(input logic [WORD_W-1:0] st,
                                   input logic [WORD_W-1:0] mk);
    return |(st & ~mk);
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              aligned_o,
  output word_sel_t         sel_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;

  assign idx       = addr_i[ADDR_W-1:2];
  assign aligned_o = (addr_i[1:0] == 2'b00);

  always_comb begin
    sel_o    = '0;
    sel_o.st = aligned_o && (idx == IDX_W'(WORD_STATUS));
    sel_o.mk = aligned_o && (idx == IDX_W'(WORD_MASK));
    sel_o.um = aligned_o && (idx == IDX_W'(WORD_UNMASK));
    sel_o.ms = aligned_o && (idx == IDX_W'(WORD_MSKSET));
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_regs_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] status_q;
  logic [WORD_W-1:0]  nxt_w;

  assign nxt_w = status_next(WORD_W'(status_q), WORD_W'(set_i), WORD_W'(clr_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt_w[NUM_SRC-1:0];
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_regs_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] unmask_i,
  input  logic [NUM_SRC-1:0] mskset_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [WORD_W-1:0]  nxt_w;

  assign nxt_w = mask_next(WORD_W'(mask_q), WORD_W'(unmask_i), WORD_W'(mskset_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= nxt_w[NUM_SRC-1:0];
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/masked_irq_regs.sv
module masked_irq_regs
  import irq_regs_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  output logic [31:0]        rd_data_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o
);
  logic               aligned;
  word_sel_t          sel;
  logic               wr_status_hit;
  logic               wr_unmask_hit;
  logic               wr_mskset_hit;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] clr_bits;
  logic [NUM_SRC-1:0] unmask_bits;
  logic [NUM_SRC-1:0] mskset_bits;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               irq_next;
  logic               irq_q;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .aligned_o (aligned),
    .sel_o     (sel)
  );

  assign wbits         = wr_data_i[NUM_SRC-1:0];
  assign wr_status_hit = wr_en_i && sel.st;
  assign wr_unmask_hit = wr_en_i && sel.um;
  assign wr_mskset_hit = wr_en_i && sel.ms;
  assign clr_bits      = wr_status_hit ? wbits : '0;
  assign unmask_bits   = wr_unmask_hit ? wbits : '0;
  assign mskset_bits   = wr_mskset_hit ? wbits : '0;

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_i),
    .clr_i    (clr_bits),
    .status_o (status_q)
  );

  irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .unmask_i (unmask_bits),
    .mskset_i (mskset_bits),
    .mask_o   (mask_q)
  );

  assign irq_next = pending(WORD_W'(status_q), WORD_W'(mask_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next;
  end

  assign irq_o = irq_q;

  always_comb begin
    rd_data_o = '0;
    if (sel.st) rd_data_o = 32'(status_q);
    if (sel.mk) rd_data_o = 32'(mask_q);
  end
endmodule

// File: rtl/masked_irq_regs_chk.sv
module masked_irq_regs_chk #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        wr_data_i,
  input logic [31:0]        rd_data_o,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               irq_o,
  input logic               wr_unmask_hit,
  input logic               wr_mskset_hit,
  input logic               aligned,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);
  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  p_irq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) == '0) |=> !irq_o);

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_unmask_hit && !wr_mskset_hit) |=> $stable(mask_q));

  p_unmask_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask_hit |=> ((mask_q & $past(wr_data_i[NUM_SRC-1:0])) == '0));

  p_mskset_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mskset_hit |=> ((mask_q & $past(wr_data_i[NUM_SRC-1:0])) == $past(wr_data_i[NUM_SRC-1:0])));

  p_misaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> (rd_data_o == '0));
endmodule

bind masked_irq_regs masked_irq_regs_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_data_i     (wr_data_i),
  .rd_data_o     (rd_data_o),
  .evt_i         (evt_i),
  .irq_o         (irq_o),
  .wr_unmask_hit (wr_unmask_hit),
  .wr_mskset_hit (wr_mskset_hit),
  .aligned       (aligned),
  .status_q      (status_q),
  .mask_q        (mask_q)
);

// File: tb/masked_irq_regs_tb_top.sv
module masked_irq_regs_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [N-1:0] evt = '0;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  masked_irq_regs #(.NUM_SRC(N), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .evt_i(evt), .irq_o(irq)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] wa;
    logic [3:0] wd;
    logic [3:0] ev;
    logic [3:0] ca;
    logic [3:0] er;
    logic       ei;
  } vec_t;

  // Reset state: status 0000, mask 1111.
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, 4'h0, 4'b0011, 4'h0, 4'b0011, 1'b0}, // R3 set, masked
    '{1'b0, 4'h0, 4'h0, 4'b0000, 4'h0, 4'b0011, 1'b0}, // R3 sticky
    '{1'b1, 4'h4, 4'h0, 4'b0000, 4'h4, 4'b1111, 1'b0}, // R6 write ignored
    '{1'b1, 4'h8, 4'h1, 4'b0000, 4'h4, 4'b1110, 1'b1}, // R7 unmask bit0, R2
    '{1'b1, 4'h0, 4'h2, 4'b0000, 4'h0, 4'b0001, 1'b1}, // R4 clear bit1 only
    '{1'b1, 4'h0, 4'h1, 4'b0000, 4'h0, 4'b0000, 1'b0}, // R4 clear bit0, R2
    '{1'b1, 4'h8, 4'h6, 4'b0000, 4'h4, 4'b1000, 1'b0}, // R7 two bits
    '{1'b0, 4'h0, 4'h0, 4'b0100, 4'h0, 4'b0100, 1'b1}, // R2 unmasked event
    '{1'b1, 4'hC, 4'h4, 4'b0000, 4'h4, 4'b1100, 1'b0}, // R8 mask bit2
    '{1'b1, 4'hC, 4'h3, 4'b0000, 4'h4, 4'b1111, 1'b0}, // R8 mask bits 1:0
    '{1'b0, 4'h0, 4'h0, 4'b0000, 4'h8, 4'b0000, 1'b0}, // R9 unmask word reads 0
    '{1'b0, 4'h0, 4'h0, 4'b0000, 4'hC, 4'b0000, 1'b0}  // R9 mskset word reads 0
  };
  localparam string TAG [NV] = '{"R3", "R3", "R6", "R7", "R4", "R4",
                                 "R7", "R2", "R8", "R8", "R9", "R9"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_at(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rd_data;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    read_at(4'h0, v); check("R1 status", v, 32'h0);
    read_at(4'h4, v); check("R1 mask", v, 32'hF);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i].wr; addr = VEC[i].wa; wr_data = 32'(VEC[i].wd); evt = VEC[i].ev;
      @(negedge clk);
      wr_en = 1'b0; evt = '0; wr_data = '0; addr = VEC[i].ca;
      @(negedge clk);
      check(TAG[i], rd_data, 32'(VEC[i].er));
      check(TAG[i], {31'b0, irq}, {31'b0, VEC[i].ei});
    end

    // R5: state status 0100, mask 1111; event and clear on bit0 together
    wr_en = 1'b1; addr = 4'h0; wr_data = 32'h1; evt = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0; evt = '0; wr_data = '0;
    read_at(4'h0, v); check("R5 set wins", v, 32'h5);

    // R10: misaligned all-ones write to an unmask alias address
    wr_en = 1'b1; addr = 4'h9; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    read_at(4'h4, v); check("R10 mask kept", v, 32'hF);
    read_at(4'h5, v); check("R10 misaligned read", v, 32'h0);
    read_at(4'h1, v); check("R10 misaligned status read", v, 32'h0);

    // R2 latency: unmask bit0, irq rises one edge after mask changes
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h8; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check("R2 latency low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R2 latency high", {31'b0, irq}, 32'h1);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule